// File: doc/BRIEF.md
# Raw Sample Capture Selector

This block takes the parallel sample word from the ADC deserializer, with one 18-bit value per channel arriving at the sample rate, and sends it to one of three places. The host picks the place with a run-mode setting. In full capture mode, once the host arms it, every channel of every sample instant is written into one capture memory. Capture stops when the memory is full, so every channel can be characterised. In group capture mode, the four channels of one selected receiver group are packed with the current switching bit into one entry. Entries go into two memories in turn, so the host can drain one buffer while the other fills. In processing mode the sample word is passed on, registered, to the demodulator, and neither memory is written.

Mode and group settings written by the host are held as pending values. They take effect only on a frame-boundary pulse, and a change restarts capture from a clean pointer state. Both memories are simple dual-port arrays. Each has a registered read port for the host.

Top module: `raw_capture_selector`

## Requirements
- R1: After reset the run mode reads 2 (processing), the group reads 0, and cap_done, buf_full, overflow, fill_buf and demod_valid are all 0.
- R2: A host write of cfg_mode/cfg_group changes run_mode/cur_group only at the next frame_tick. A write with mode code 3 is rejected whole. Mode codes: 0 full capture, 1 group capture, 2 processing.
- R3: In processing mode each valid sample appears on demod_data with its switching bit on demod_switch, with demod_valid high, one cycle after it is presented. No capture flag moves.
- R4: In full capture mode an arm pulse starts capture at address 0. Each valid sample goes to the next address, and each entry holds channel c in bits [18c+17:18c]. cap_done rises with the write that fills the last address. Later samples are not stored.
- R5: An arm pulse given outside full capture mode is ignored.
- R6: In group capture mode an entry holds the switching bit in bit 72. Bits [18k+17:18k] hold channel 4*g+k, where g is the active group.
- R7: Group capture fills buffer 0 from address 0, then buffer 1. Filling a buffer sets its bit in buf_full, and fill_buf then names the other buffer.
- R8: A sample whose target buffer is still full is dropped, and the sticky overflow bit is set. A clr_full pulse frees that buffer, and writing resumes at its address 0. overflow stays set until clr_ovf.
- R9: An applied change of mode or group clears the write pointers, fill_buf, buf_full, cap_done and the armed state.
- R10: Both host read ports return the addressed entry one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample word valid strobe |
| smp_data | input | NUM_CH*18 | Parallel sample word, channel c in bits [18c+17:18c] |
| switch_bit | input | 1 | Current state of the switching signal |
| frame_tick | input | 1 | Frame-boundary pulse |
| cfg_we | input | 1 | Host write of the pending mode and group |
| cfg_mode | input | 2 | Requested mode code |
| cfg_group | input | GRP_W | Requested receiver group |
| arm | input | 1 | Start a full capture |
| clr_full | input | 2 | Per-buffer full-flag clear pulses |
| clr_ovf | input | 1 | Clear the overflow bit |
| full_rd_addr | input | log2(FULL_DEPTH) | Full capture memory read address |
| raw_rd_buf | input | 1 | Group buffer to read |
| raw_rd_addr | input | log2(RAW_DEPTH) | Group buffer read address |
| run_mode | output | 2 | Active mode code |
| cur_group | output | GRP_W | Active receiver group |
| cap_done | output | 1 | Full capture finished |
| buf_full | output | 2 | Per-buffer full flags |
| overflow | output | 1 | Sticky dropped-sample flag |
| fill_buf | output | 1 | Buffer being filled |
| full_rd_data | output | NUM_CH*18 | Full capture read data |
| raw_rd_data | output | 73 | Group buffer read data |
| demod_valid | output | 1 | Sample valid towards the demodulator |
| demod_data | output | NUM_CH*18 | Sample word towards the demodulator |
| demod_switch | output | 1 | Switching bit towards the demodulator |

## Verification
The demodulator outputs are registered once, so they are due one cycle after the edge that takes a sample. Flags and the fill pointer change on the same edge as the write that causes them. A mode or group change shows on the frame_tick edge. Read data comes one cycle after the address. The bench drives every input on the falling edge and samples every output on the next falling edge, half a cycle after the edge that should have produced it, so each check lands on the first cycle its result is due.

// File: rtl/capsel_pkg.sv
package capsel_pkg;
    localparam int SMP_W  = 18;
    localparam int GRP_CH = 4;
    localparam int ENTRY_W = GRP_CH * SMP_W + 1;

    typedef enum logic [1:0] {
        RUN_FULL  = 2'd0,
        RUN_GROUP = 2'd1,
        RUN_DEMOD = 2'd2
    } run_mode_e;

    typedef struct packed {
        logic                      sw;
        logic [GRP_CH*SMP_W-1:0]   samples;
    } grp_entry_t;

    function automatic logic mode_code_ok(input logic [1:0] code);
        return code != 2'd3;
    endfunction
endpackage

// File: rtl/capsel_sdp_ram.sv
module capsel_sdp_ram #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/capsel_mode_ctrl.sv
module capsel_mode_ctrl
    import capsel_pkg::*;
#(
    parameter int GRP_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic [GRP_W-1:0] cfg_group,
    input  logic             frame_tick,
    output run_mode_e        act_mode,
    output logic [GRP_W-1:0] act_group,
    output logic             restart
);
    run_mode_e        pend_mode, nxt_mode;
    logic [GRP_W-1:0] pend_group, nxt_group;

    always_comb begin
        nxt_mode  = pend_mode;
        nxt_group = pend_group;
        if (cfg_we && mode_code_ok(cfg_mode)) begin
            nxt_mode  = run_mode_e'(cfg_mode);
            nxt_group = cfg_group;
        end
        restart = frame_tick && ((nxt_mode != act_mode) || (nxt_group != act_group));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_mode  <= RUN_DEMOD;
            pend_group <= '0;
            act_mode   <= RUN_DEMOD;
            act_group  <= '0;
        end else begin
            pend_mode  <= nxt_mode;
            pend_group <= nxt_group;
            if (frame_tick) begin
                act_mode  <= nxt_mode;
                act_group <= nxt_group;
            end
        end
    end

    AST_MODE_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> ($stable(act_mode) && $stable(act_group))); // R2

    AST_NO_BAD_CODE: assert property (@(posedge clk) disable iff (rst)
        act_mode != 2'd3); // R2
endmodule

// File: rtl/capsel_full_capture.sv
module capsel_full_capture #(
    parameter int W     = 144,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          mode_full,
    input  logic          arm,
    input  logic          smp_valid,
    input  logic [W-1:0]  smp_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    output logic          done,
    output logic          wr_en
);
    logic          armed;
    logic [AW-1:0] ptr;
    logic          arm_ok;

    assign arm_ok = arm && mode_full;
    assign wr_en  = armed && mode_full && smp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            done  <= 1'b0;
            ptr   <= '0;
        end else if (restart) begin
            armed <= 1'b0;
            done  <= 1'b0;
            ptr   <= '0;
        end else if (arm_ok) begin
            armed <= 1'b1;
            done  <= 1'b0;
            ptr   <= '0;
        end else if (wr_en) begin
            if (ptr == AW'(DEPTH - 1)) begin
                armed <= 1'b0;
                done  <= 1'b1;
                ptr   <= '0;
            end else begin
                ptr <= ptr + AW'(1);
            end
        end
    end

    capsel_sdp_ram #(.W(W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (ptr),
        .wdata (smp_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_en); // R4

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && !arm_ok && !restart) |=> done); // R4

    AST_ARM_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
        (!mode_full && !armed) |=> !armed); // R5
endmodule

// File: rtl/capsel_pingpong.sv
module capsel_pingpong
    import capsel_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DEPTH  = 4,
    parameter int GRP_W  = 1,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    restart,
    input  logic                    mode_grp,
    input  logic [GRP_W-1:0]        group,
    input  logic                    smp_valid,
    input  logic [NUM_CH*SMP_W-1:0] smp_data,
    input  logic                    switch_bit,
    input  logic [1:0]              clr_full,
    input  logic                    clr_ovf,
    input  logic                    rd_buf,
    input  logic [AW-1:0]           rd_addr,
    output logic [ENTRY_W-1:0]      rd_data,
    output logic [1:0]              full,
    output logic                    ovf,
    output logic                    wr_buf,
    output logic                    wr_en
);
    grp_entry_t          entry;
    logic [AW-1:0]       ptr;
    logic                accept, drop, last;
    logic [1:0]          full_n;
    logic                rd_sel_q;
    logic [ENTRY_W-1:0]  rdat [2];

    always_comb begin
        entry.sw = switch_bit;
        for (int k = 0; k < GRP_CH; k++) begin
            entry.samples[k*SMP_W +: SMP_W] =
                smp_data[(int'(group) * GRP_CH + k) * SMP_W +: SMP_W];
        end
    end

    assign accept = mode_grp && smp_valid;
    assign wr_en  = accept && !full[wr_buf];
    assign drop   = accept && full[wr_buf];
    assign last   = (ptr == AW'(DEPTH - 1));

    always_comb begin
        full_n = full & ~clr_full;
        if (wr_en && last) full_n[wr_buf] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr    <= '0;
            wr_buf <= 1'b0;
            full   <= 2'b00;
            ovf    <= 1'b0;
        end else begin
            if (drop)         ovf <= 1'b1;
            else if (clr_ovf) ovf <= 1'b0;
            if (restart) begin
                ptr    <= '0;
                wr_buf <= 1'b0;
                full   <= 2'b00;
            end else begin
                full <= full_n;
                if (wr_en) begin
                    if (last) begin
                        ptr    <= '0;
                        wr_buf <= ~wr_buf;
                    end else begin
                        ptr <= ptr + AW'(1);
                    end
                end
            end
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_buf
        capsel_sdp_ram #(.W(ENTRY_W), .DEPTH(DEPTH)) u_mem (
            .clk   (clk),
            .we    (wr_en && (wr_buf == 1'(b))),
            .waddr (ptr),
            .wdata (entry),
            .raddr (rd_addr),
            .rdata (rdat[b])
        );
    end

    always_ff @(posedge clk) rd_sel_q <= rd_buf;
    assign rd_data = rdat[rd_sel_q];

    AST_OVF_FROM_GROUP: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(mode_grp)); // R8

    AST_SWAP_ON_FILL: assert property (@(posedge clk) disable iff (rst)
        !$stable(wr_buf) |-> ($past(wr_en) || $past(restart))); // R7

    AST_FULL_SETS_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        ($countones(full) > $countones($past(full))) |-> $past(wr_en)); // R7
endmodule

// File: rtl/raw_capture_selector.sv
module raw_capture_selector
    import capsel_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int FULL_DEPTH = 8,
    parameter int RAW_DEPTH  = 4,
    localparam int NGRP  = NUM_CH / GRP_CH,
    localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1,
    localparam int FAW   = (FULL_DEPTH > 1) ? $clog2(FULL_DEPTH) : 1,
    localparam int RAW_W = (RAW_DEPTH > 1) ? $clog2(RAW_DEPTH) : 1,
    localparam int WORD_W = NUM_CH * SMP_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_valid,
    input  logic [WORD_W-1:0]  smp_data,
    input  logic               switch_bit,
    input  logic               frame_tick,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_mode,
    input  logic [GRP_W-1:0]   cfg_group,
    input  logic               arm,
    input  logic [1:0]         clr_full,
    input  logic               clr_ovf,
    input  logic [FAW-1:0]     full_rd_addr,
    input  logic               raw_rd_buf,
    input  logic [RAW_W-1:0]   raw_rd_addr,
    output logic [1:0]         run_mode,
    output logic [GRP_W-1:0]   cur_group,
    output logic               cap_done,
    output logic [1:0]         buf_full,
    output logic               overflow,
    output logic               fill_buf,
    output logic [WORD_W-1:0]  full_rd_data,
    output logic [ENTRY_W-1:0] raw_rd_data,
    output logic               demod_valid,
    output logic [WORD_W-1:0]  demod_data,
    output logic               demod_switch
);
    run_mode_e act_mode;
    logic      restart;
    logic      full_we, grp_we;

    capsel_mode_ctrl #(.GRP_W(GRP_W)) u_mode (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_mode   (cfg_mode),
        .cfg_group  (cfg_group),
        .frame_tick (frame_tick),
        .act_mode   (act_mode),
        .act_group  (cur_group),
        .restart    (restart)
    );

    assign run_mode = act_mode;

    capsel_full_capture #(.W(WORD_W), .DEPTH(FULL_DEPTH)) u_full (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .mode_full (act_mode == RUN_FULL),
        .arm       (arm),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .rd_addr   (full_rd_addr),
        .rd_data   (full_rd_data),
        .done      (cap_done),
        .wr_en     (full_we)
    );

    capsel_pingpong #(.NUM_CH(NUM_CH), .DEPTH(RAW_DEPTH), .GRP_W(GRP_W)) u_pp (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .mode_grp   (act_mode == RUN_GROUP),
        .group      (cur_group),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .switch_bit (switch_bit),
        .clr_full   (clr_full),
        .clr_ovf    (clr_ovf),
        .rd_buf     (raw_rd_buf),
        .rd_addr    (raw_rd_addr),
        .rd_data    (raw_rd_data),
        .full       (buf_full),
        .ovf        (overflow),
        .wr_buf     (fill_buf),
        .wr_en      (grp_we)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            demod_valid  <= 1'b0;
            demod_data   <= '0;
            demod_switch <= 1'b0;
        end else begin
            demod_valid  <= smp_valid && (act_mode == RUN_DEMOD);
            demod_data   <= smp_data;
            demod_switch <= switch_bit;
        end
    end

    AST_ONE_SINK: assert property (@(posedge clk) disable iff (rst)
        $onehot0({full_we, grp_we})); // R3

    AST_DEMOD_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        demod_valid |-> (!$past(full_we) && !$past(grp_we))); // R3
endmodule

// File: tb/raw_capture_selector_tb.sv
module raw_capture_selector_tb_top;
    import capsel_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 8;
    localparam int FULL_DEPTH = 8;
    localparam int RAW_DEPTH = 4;
    localparam int WORD_W = NUM_CH * SMP_W;

    logic clk = 1'b0;
    logic rst;
    logic smp_valid, switch_bit, frame_tick, cfg_we, arm, clr_ovf, raw_rd_buf;
    logic [WORD_W-1:0] smp_data;
    logic [1:0] cfg_mode, clr_full;
    logic [0:0] cfg_group;
    logic [2:0] full_rd_addr;
    logic [1:0] raw_rd_addr;
    logic [1:0] run_mode, buf_full;
    logic [0:0] cur_group;
    logic cap_done, overflow, fill_buf, demod_valid, demod_switch;
    logic [WORD_W-1:0] full_rd_data, demod_data;
    logic [ENTRY_W-1:0] raw_rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    raw_capture_selector #(.NUM_CH(NUM_CH), .FULL_DEPTH(FULL_DEPTH), .RAW_DEPTH(RAW_DEPTH)) dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .switch_bit(switch_bit), .frame_tick(frame_tick), .cfg_we(cfg_we),
        .cfg_mode(cfg_mode), .cfg_group(cfg_group), .arm(arm), .clr_full(clr_full),
        .clr_ovf(clr_ovf), .full_rd_addr(full_rd_addr), .raw_rd_buf(raw_rd_buf),
        .raw_rd_addr(raw_rd_addr), .run_mode(run_mode), .cur_group(cur_group),
        .cap_done(cap_done), .buf_full(buf_full), .overflow(overflow),
        .fill_buf(fill_buf), .full_rd_data(full_rd_data), .raw_rd_data(raw_rd_data),
        .demod_valid(demod_valid), .demod_data(demod_data), .demod_switch(demod_switch)
    );

    // table: {switch bit, seed}
    localparam logic [8:0] VEC [4] = '{9'h003, 9'h111, 9'h02A, 9'h163};

    function automatic logic [WORD_W-1:0] mk_word(input int seed);
        logic [WORD_W-1:0] w;
        for (int c = 0; c < NUM_CH; c++) w[c*SMP_W +: SMP_W] = SMP_W'(seed * 1237 + c * 4099 + 11);
        return w;
    endfunction

    function automatic logic [ENTRY_W-1:0] grp_exp(input int seed, input logic sw, input int g);
        logic [WORD_W-1:0] w;
        w = mk_word(seed);
        return {sw, w[g*GRP_CH*SMP_W +: GRP_CH*SMP_W]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input int seed, input logic sw);
        smp_data = mk_word(seed); switch_bit = sw; smp_valid = 1'b1;
        @(negedge clk); smp_valid = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic g);
        cfg_we = 1'b1; cfg_mode = m; cfg_group = g;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic tick();
        frame_tick = 1'b1; @(negedge clk); frame_tick = 1'b0;
    endtask

    task automatic read_raw(input logic b, input int a, output logic [ENTRY_W-1:0] d);
        raw_rd_buf = b; raw_rd_addr = 2'(a); @(negedge clk); d = raw_rd_data;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [ENTRY_W-1:0] rd;
        rst = 1'b1; smp_valid = 0; smp_data = '0; switch_bit = 0; frame_tick = 0;
        cfg_we = 0; cfg_mode = 0; cfg_group = 0; arm = 0; clr_full = 0; clr_ovf = 0;
        full_rd_addr = 0; raw_rd_buf = 0; raw_rd_addr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(run_mode == 2'd2 && cur_group == 0, "R1", {run_mode, cur_group}, 3'b100);
        check({cap_done, buf_full, overflow, fill_buf, demod_valid} == 6'b0, "R1",
              {cap_done, buf_full, overflow, fill_buf, demod_valid}, 0);

        // R3 table walk in processing mode
        for (int i = 0; i < 4; i++) begin
            send(int'(VEC[i][7:0]), VEC[i][8]);
            check(demod_valid && demod_data == mk_word(int'(VEC[i][7:0])) && demod_switch == VEC[i][8],
                  "R3", {demod_valid, demod_switch, demod_data}, {1'b1, VEC[i][8], mk_word(int'(VEC[i][7:0]))});
        end
        @(negedge clk);
        check(!demod_valid, "R3", demod_valid, 0);
        check(buf_full == 0 && !cap_done, "R3", {buf_full, cap_done}, 0);

        // R5 arm outside full mode
        arm = 1'b1; @(negedge clk); arm = 1'b0;

        // R2 bad code rejected, change only at frame tick
        set_cfg(2'd3, 1'b1); tick();
        check(run_mode == 2'd2 && cur_group == 0, "R2", {run_mode, cur_group}, 3'b100);
        set_cfg(2'd0, 1'b0); @(negedge clk);
        check(run_mode == 2'd2, "R2", run_mode, 2);
        tick();
        check(run_mode == 2'd0, "R2", run_mode, 0);

        for (int i = 0; i < FULL_DEPTH; i++) send(50 + i, 1'b0);
        check(!cap_done, "R5", cap_done, 0);

        // R4 full capture
        arm = 1'b1; @(negedge clk); arm = 1'b0;
        for (int i = 0; i < FULL_DEPTH - 1; i++) send(100 + i, 1'b0);
        check(!cap_done, "R4", cap_done, 0);
        send(100 + FULL_DEPTH - 1, 1'b0);
        check(cap_done, "R4", cap_done, 1);
        send(200, 1'b0); send(201, 1'b0);
        for (int a = 0; a < FULL_DEPTH; a++) begin
            full_rd_addr = 3'(a); @(negedge clk);
            check(full_rd_data == mk_word(100 + a), "R4 R10", full_rd_data, mk_word(100 + a));
        end
        check(cap_done, "R4", cap_done, 1);

        // R9 change to group mode clears done
        set_cfg(2'd1, 1'b1); tick();
        check(run_mode == 2'd1 && cur_group == 1 && !cap_done, "R9", {run_mode, cur_group, cap_done}, 4'b0110);

        // R7 buffer 0 then buffer 1
        for (int i = 0; i < RAW_DEPTH; i++) send(300 + i, 1'(i));
        check(buf_full == 2'b01 && fill_buf, "R7", {buf_full, fill_buf}, 3'b011);
        for (int a = 0; a < RAW_DEPTH; a++) begin
            read_raw(1'b0, a, rd);
            check(rd == grp_exp(300 + a, 1'(a), 1), "R6", rd, grp_exp(300 + a, 1'(a), 1));
        end
        for (int i = 0; i < RAW_DEPTH; i++) send(310 + i, 1'b1);
        check(buf_full == 2'b11 && !fill_buf, "R7", {buf_full, fill_buf}, 3'b110);

        // R8 drop and overflow
        check(!overflow, "R8", overflow, 0);
        send(320, 1'b0);
        check(overflow && buf_full == 2'b11, "R8", {overflow, buf_full}, 3'b111);
        read_raw(1'b1, 0, rd);
        check(rd == grp_exp(310, 1'b1, 1), "R7", rd, grp_exp(310, 1'b1, 1));
        clr_full = 2'b01; @(negedge clk); clr_full = 2'b00;
        check(buf_full == 2'b10, "R8", buf_full, 2'b10);
        send(330, 1'b1);
        read_raw(1'b0, 0, rd);
        check(rd == grp_exp(330, 1'b1, 1), "R8", rd, grp_exp(330, 1'b1, 1));
        read_raw(1'b0, 1, rd);
        check(rd == grp_exp(301, 1'b1, 1), "R8", rd, grp_exp(301, 1'b1, 1));
        check(overflow, "R8", overflow, 1);
        clr_ovf = 1'b1; @(negedge clk); clr_ovf = 1'b0;
        check(!overflow, "R8", overflow, 0);

        // R9 group change resets pointers and flags
        set_cfg(2'd1, 1'b0); tick();
        check(buf_full == 0 && !fill_buf && cur_group == 0, "R9", {buf_full, fill_buf, cur_group}, 0);
        send(340, 1'b1);
        read_raw(1'b0, 0, rd);
        check(rd == grp_exp(340, 1'b1, 0), "R9 R6", rd, grp_exp(340, 1'b1, 0));

        // R3 back to processing: no capture
        set_cfg(2'd2, 1'b0); tick();
        for (int i = 0; i < RAW_DEPTH; i++) send(400 + i, 1'b0);
        check(demod_valid && demod_data == mk_word(403), "R3", demod_data, mk_word(403));
        check(buf_full == 0 && !fill_buf, "R3", {buf_full, fill_buf}, 0);
        read_raw(1'b0, 0, rd);
        check(rd == grp_exp(340, 1'b1, 0), "R3", rd, grp_exp(340, 1'b1, 0));

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule